// File: doc/BRIEF.md
# Byte-Lane SEC-DED Memory Wrapper

This wrapper sits between a 32-bit bus-side memory port and a plain synchronous RAM array. It splits every word into four byte lanes and gives each lane its own 13-bit code word: 8 data bits, 4 Hamming check bits and 1 overall parity bit. A write stores each enabled lane's data and check bits in the cycle it is issued. A read recomputes each lane's syndrome. A single flipped bit in a lane is corrected in the value returned to the reader, while two flipped bits are flagged as uncorrectable. The stored array is never repaired by the wrapper. A corrupted word stays corrupted until software writes it again, and a corrupted word that is never read is never reported.

A small two-state machine tracks the read response. `ST_IDLE` moves to `ST_RESP` on the transition `rd_go` (a read request). `ST_RESP` stays in `ST_RESP` on a further `rd_go` and returns to `ST_IDLE` on `no_rd`. Data, per-lane flags and the error report are valid while the machine is in `ST_RESP`, which is the cycle after the read address. A checking enable is captured with each read. When it is low, the raw stored data comes back and no error is reported.

Top module: `lane_secded_ram`

## Requirements
- R1: Each lane k occupies `ram_wdata[13k+12 : 13k]`. Bits 12..5 hold the data byte, bit 4 holds the overall parity and bits 3..0 hold Hamming checks c0..c3. Data bits 0..7 sit at Hamming positions 3,5,6,7,9,10,11,12. Check cj is the XOR of the data bits whose position has bit j set. The overall bit is the XOR of the other 12 bits.
- R2: A write request drives `ram_en`=1, `ram_addr`=`bus_addr` and `ram_we`=`bus_be` in the same cycle.
- R3: `bus_rvalid` is 1 exactly in the cycle after a read request. At reset it is 0.
- R4: A read of a lane with no error returns the stored byte and raises neither lane flag.
- R5: A single flipped data bit in a lane is corrected in `bus_rdata` and sets that lane's `lane_sec` bit. A second read of the same word reports it again, because the array is not repaired.
- R6: A single flipped check bit (any of bits 4..0) sets `lane_sec` and leaves the returned byte equal to the stored byte.
- R7: Two flipped bits in one lane set `lane_ded` for that lane and clear its `lane_sec` bit. A lane never shows both flags.
- R8: Lanes are classified independently. Errors in several lanes of one word are flagged per lane, and clean lanes return their data.
- R9: `err_valid` is 1 in the response cycle when any lane flag is set. `err_addr` then equals the word address of that read.
- R10: If `chk_en` is 0 at the read request, the response carries the raw stored bytes, and all flags and `err_valid` are 0.
- R11: A byte-enable write changes only the enabled lanes. Disabled lanes read back their previous bytes.
- R12: After reset, all lane flags and `err_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Checking enable, captured with each read |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte-lane write enables |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Corrected read data |
| bus_rvalid | output | 1 | Read response valid |
| lane_sec | output | 4 | Per-lane corrected single error |
| lane_ded | output | 4 | Per-lane uncorrectable double error |
| err_valid | output | 1 | Error report strobe |
| err_addr | output | ADDR_W | Word address of the reported read |
| ram_en | output | 1 | Array access enable |
| ram_we | output | 4 | Array per-lane write enables |
| ram_addr | output | ADDR_W | Array word address |
| ram_wdata | output | 52 | Encoded lanes to the array |
| ram_rdata | input | 52 | Encoded lanes from the array, one cycle after access |

## Verification
All 256 byte values are written into every lane and read back clean. This separates a wrong check equation from a correct one, because any bad mask shows up as a stored-field mismatch or a false flag. Every one of the 13 bit positions in every lane is flipped singly, which tells data correction apart from check-bit and parity-bit errors. All 78 bit pairs in one lane are flipped, which separates uncorrectable errors from mis-corrections. Mixed multi-lane corruption, partial byte-enable writes and reads with checking disabled show that lanes, write masks and the bypass do not interfere with each other.

// File: rtl/lsecded_pkg.sv
package lsecded_pkg;
    localparam int LANE_DW = 8;
    localparam int HAM_W   = 4;
    localparam int LANE_CW = LANE_DW + HAM_W + 1;

    typedef enum logic {ST_IDLE, ST_RESP} rd_state_e;

    // Hamming position of data bit i (skips power-of-two slots)
    function automatic logic [3:0] data_pos(input int i);
        case (i)
            0: data_pos = 4'd3;
            1: data_pos = 4'd5;
            2: data_pos = 4'd6;
            3: data_pos = 4'd7;
            4: data_pos = 4'd9;
            5: data_pos = 4'd10;
            6: data_pos = 4'd11;
            default: data_pos = 4'd12;
        endcase
    endfunction

    function automatic logic [LANE_DW-1:0] ham_mask(input int j);
        logic [3:0] p;
        ham_mask = '0;
        for (int i = 0; i < LANE_DW; i++) begin
            p = data_pos(i);
            ham_mask[i] = p[j];
        end
    endfunction

    function automatic logic [HAM_W-1:0] ham_bits(input logic [LANE_DW-1:0] d);
        for (int j = 0; j < HAM_W; j++)
            ham_bits[j] = ^(d & ham_mask(j));
    endfunction
endpackage

// File: rtl/lane_enc.sv
module lane_enc
    import lsecded_pkg::*;
(
    input  logic [LANE_DW-1:0] data_i,
    output logic [LANE_CW-1:0] cw_o
);
    logic [HAM_W-1:0] ham;

    always_comb begin
        ham  = ham_bits(data_i);
        cw_o = {data_i, (^data_i) ^ (^ham), ham};
    end
endmodule

// File: rtl/lane_dec.sv
module lane_dec
    import lsecded_pkg::*;
(
    input  logic               chk_i,
    input  logic [LANE_CW-1:0] cw_i,
    output logic [LANE_DW-1:0] data_o,
    output logic               sec_o,
    output logic               ded_o
);
    logic [LANE_DW-1:0] raw;
    logic [HAM_W-1:0]   syn;
    logic               odd;
    logic               hit;

    always_comb begin
        raw    = cw_i[LANE_CW-1 -: LANE_DW];
        syn    = ham_bits(raw) ^ cw_i[HAM_W-1:0];
        odd    = ^cw_i;
        data_o = raw;
        sec_o  = 1'b0;
        ded_o  = 1'b0;
        hit    = 1'b0;
        if (chk_i) begin
            if (odd) begin
                if ((syn & (syn - 4'd1)) == 4'd0) begin
                    sec_o = 1'b1;           // parity or check bit
                end else begin
                    for (int i = 0; i < LANE_DW; i++) begin
                        if (data_pos(i) == syn) begin
                            data_o[i] = ~raw[i];
                            hit = 1'b1;
                        end
                    end
                    sec_o = hit;
                    ded_o = !hit;           // syndrome beyond word
                end
            end else if (syn != '0) begin
                ded_o = 1'b1;
            end
        end
    end

    always_comb begin
        p_one_class_r7: assert (!(sec_o && ded_o));
    end
endmodule

// File: rtl/lane_secded_ram.sv
module lane_secded_ram
    import lsecded_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / LANE_DW,
    localparam int RAM_W = LANES * LANE_CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [LANES-1:0]  bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [LANES-1:0]  lane_sec,
    output logic [LANES-1:0]  lane_ded,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic              ram_en,
    output logic [LANES-1:0]  ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [RAM_W-1:0]  ram_wdata,
    input  logic [RAM_W-1:0]  ram_rdata
);
    rd_state_e         state_q, state_d;
    logic              rd_go;
    logic              chk_q;
    logic [ADDR_W-1:0] addr_q;
    logic              dec_chk;
    logic [LANES-1:0]  sec_w, ded_w;

    assign rd_go = bus_req && !bus_we;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chk_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_go) begin
                chk_q  <= chk_en;
                addr_q <= bus_addr;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_go) state_d = ST_RESP;
            ST_RESP: state_d = rd_go ? ST_RESP : ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: bus_rvalid = 1'b0;
            ST_RESP: bus_rvalid = 1'b1;
        endcase
        dec_chk   = bus_rvalid && chk_q;
        ram_en    = bus_req;
        ram_we    = (bus_req && bus_we) ? bus_be : '0;
        ram_addr  = bus_addr;
        lane_sec  = sec_w;
        lane_ded  = ded_w;
        err_valid = |{sec_w, ded_w};
        err_addr  = addr_q;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_enc u_enc (
            .data_i (bus_wdata[k*LANE_DW +: LANE_DW]),
            .cw_o   (ram_wdata[k*LANE_CW +: LANE_CW])
        );
        lane_dec u_dec (
            .chk_i  (dec_chk),
            .cw_i   (ram_rdata[k*LANE_CW +: LANE_CW]),
            .data_o (bus_rdata[k*LANE_DW +: LANE_DW]),
            .sec_o  (sec_w[k]),
            .ded_o  (ded_w[k])
        );
    end

    p_wr_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (ram_en && ram_we == bus_be && ram_addr == bus_addr));
    p_read_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> bus_rvalid);
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !bus_rvalid);
    p_flag_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|{lane_sec, lane_ded}) |-> (bus_rvalid && err_valid));
    p_err_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_addr == $past(bus_addr)));
    p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !chk_en) |=> (lane_sec == '0 && lane_ded == '0 && !err_valid));
endmodule

// File: tb/sim_lane_secded_ram.sv
`timescale 1ns/1ps
module sim_lane_secded_ram;
    localparam int AW = 4;
    localparam int CW = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, err_valid, ram_en;
    logic [3:0]  lane_sec, lane_ded, ram_we;
    logic [AW-1:0] err_addr, ram_addr;
    logic [51:0] ram_wdata;
    logic [51:0] ram_rdata;
    logic [51:0] mem [16];

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lane_secded_ram #(.ADDR_W(AW)) u0 (.*);

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we == 4'h0) ram_rdata <= mem[ram_addr];
            for (int k = 0; k < 4; k++)
                if (ram_we[k]) mem[ram_addr][k*CW +: CW] <= ram_wdata[k*CW +: CW];
        end
    end

    function automatic logic [12:0] tb_code(input logic [7:0] d);
        logic [12:1] h;
        logic [3:0] c;
        int k;
        h = '0; k = 0;
        for (int p = 1; p <= 12; p++)
            if ((p & (p - 1)) != 0) begin h[p] = d[k]; k++; end
        for (int j = 0; j < 4; j++) begin
            c[j] = 1'b0;
            for (int p = 1; p <= 12; p++) if (p[j]) c[j] ^= h[p];
        end
        return {d, (^d) ^ (^c), c};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_be = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic en);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a; chk_en = en;
        @(negedge clk);
        bus_req = 0; chk_en = 1;
    endtask

    task automatic expect_rd(input string req, input logic [31:0] d, input logic [3:0] s,
                             input logic [3:0] dd, input logic [AW-1:0] a);
        chk({req, " rvalid"}, bus_rvalid, 1'b1);
        chk({req, " data"}, bus_rdata, d);
        chk({req, " sec"}, lane_sec, s);
        chk({req, " ded"}, lane_ded, dd);
        chk({req, " err_valid"}, err_valid, |{s, dd});
        if (|{s, dd}) chk({req, " err_addr R9"}, err_addr, a);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, raw;
        for (int a = 0; a < 16; a++) mem[a] = '0;
        ram_rdata = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 rvalid", bus_rvalid, 0);
        chk("R12 flags", {lane_sec, lane_ded, err_valid}, 0);
        rst_n = 1;

        // R1 R4: every byte value in every lane
        for (int v = 0; v < 256; v++) begin
            w = {8'(v + 1), ~8'(v), 8'(v) ^ 8'hA5, 8'(v)};
            wr(AW'(v), w, 4'hF);
            for (int k = 0; k < 4; k++)
                chk("R1 stored field", mem[AW'(v)][k*CW +: CW], tb_code(w[k*8 +: 8]));
            rd(AW'(v), 1);
            expect_rd("R4", w, 0, 0, AW'(v));
        end
        // R3: no response without a read
        @(negedge clk);
        chk("R3 idle rvalid", bus_rvalid, 0);

        // R11 byte-enable
        wr(3, 32'h11223344, 4'hF);
        wr(3, 32'hAABBCCDD, 4'b0010);
        rd(3, 1);
        expect_rd("R11", 32'h1122CC44, 0, 0, 3);
        wr(3, 32'h99887766, 4'b1001);
        rd(3, 1);
        expect_rd("R11", 32'h9922CC66, 0, 0, 3);

        // R5 R6 single flips in all positions of all lanes
        w = 32'h5AC3_0FE1;
        for (int l = 0; l < 4; l++)
            for (int b = 0; b < 13; b++) begin
                wr(5, w, 4'hF);
                mem[5][l*CW + b] = ~mem[5][l*CW + b];
                rd(5, 1);
                expect_rd(b >= 5 ? "R5" : "R6", w, 4'(1 << l), 0, 5);
                rd(5, 1);
                expect_rd(b >= 5 ? "R5 reread" : "R6 reread", w, 4'(1 << l), 0, 5);
            end

        // R7 all double flips in lane 2
        w = 32'h3C96_E187;
        for (int b1 = 0; b1 < 13; b1++)
            for (int b2 = b1 + 1; b2 < 13; b2++) begin
                wr(9, w, 4'hF);
                mem[9][2*CW + b1] = ~mem[9][2*CW + b1];
                mem[9][2*CW + b2] = ~mem[9][2*CW + b2];
                rd(9, 1);
                chk("R7 ded", lane_ded, 4'b0100);
                chk("R7 sec", lane_sec, 4'b0000);
                chk("R7 err_valid", err_valid, 1);
                chk("R7 err_addr R9", err_addr, 9);
                chk("R7 clean lanes", {bus_rdata[31:24], bus_rdata[15:0]}, {w[31:24], w[15:0]});
            end

        // R8 mixed lanes
        w = 32'hDEAD_BEEF;
        wr(12, w, 4'hF);
        mem[12][0*CW + 7] = ~mem[12][0*CW + 7];
        mem[12][3*CW + 1] = ~mem[12][3*CW + 1];
        mem[12][3*CW + 10] = ~mem[12][3*CW + 10];
        rd(12, 1);
        chk("R8 sec", lane_sec, 4'b0001);
        chk("R8 ded", lane_ded, 4'b1000);
        chk("R8 data", bus_rdata[23:0], w[23:0]);
        chk("R8 err_addr R9", err_addr, 12);

        // R10 bypass returns raw data
        w = 32'h0F0F_A55A;
        wr(7, w, 4'hF);
        mem[7][1*CW + 6] = ~mem[7][1*CW + 6];   // data bit 1 of lane 1
        mem[7][2*CW + 0] = ~mem[7][2*CW + 0];
        mem[7][2*CW + 9] = ~mem[7][2*CW + 9];   // data bit 4 of lane 2
        raw = w ^ 32'h0010_0200;
        rd(7, 0);
        expect_rd("R10", raw, 0, 0, 7);
        rd(7, 1);
        expect_rd("R10 recheck", {w[31:16] ^ 16'h0010, w[15:0]}, 4'b0010, 4'b0100, 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule